// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages a small pool of fixed-size packet buffer pages for a network controller. It keeps a bitmap of which pages are in use and three queues of page numbers: pages waiting to be transmitted, pages whose transmission has finished, and pages holding received frames. Software drives it with one command byte per access, whose upper three bits select the operation. The frame memory itself, CRC handling and the line-side transmitter are outside the block: the transmitter sees a request level with the page at the head of the transmit queue and answers with a one-cycle completion pulse per page.

Transmit allocation has a sticky failure: when no page is free the result reads 0x80 and the request stays pending. The first later release of any page completes it automatically, so software can simply wait for the allocation status flag. The receive side asks for a page with a single-cycle request and is granted the lowest free page whenever no command is being executed in that cycle.

Top module: `pkt_page_mmu`

## Requirements
- R1: The command code is `cmd_byte[7:5]`, taken only when `cmd_valid` is high; code 0 leaves every output and all state unchanged.
- R2: Code 1 grants the lowest-numbered free page: from the next cycle `alloc_result` holds the page number (bit 7 clear) and `alloc_irq` is 1. With every page in use `alloc_result` reads 0x80 and `alloc_irq` is 0.
- R3: While `alloc_result` is 0x80, any page release completes the pending allocation at the same clock edge, raising `alloc_irq` and loading the lowest free page.
- R4: Code 2 empties the bitmap and all three queues and sets `alloc_result` to 0.
- R5: `rx_head` and `done_head` read 0x80 when their queue is empty and otherwise the oldest entry, zero-extended.
- R6: Code 3 drops the oldest receive entry; code 4 drops it and frees its page; both do nothing on an empty receive queue.
- R7: Code 5 frees page `pkt_sel`; code 6 appends `pkt_sel` to the transmit queue, and is ignored when that queue already holds four entries.
- R8: `tx_req` is high only while `tx_enable` is 1 and the transmit queue is non-empty; `tx_page` is its oldest entry, and `tx_done` with `tx_req` high removes that entry.
- R9: On completion the page is freed when `auto_release` is 1; otherwise it is appended to the done queue if that queue has room. `done_pop` removes the oldest done entry.
- R10: `rx_grant` is high in the same cycle as `rx_req` when a page is free and `cmd_valid` is low; the granted page `rx_page` is the lowest free page and is appended to the receive queue.
- R11: `mem_size` always reads 4 and `used_count` reports the number of pages in use.
- R12: Code 7 empties the transmit and done queues and leaves the bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command byte, code in bits 7:5 |
| pkt_sel | input | 2 | Packet number used by release and enqueue |
| tx_enable | input | 1 | Transmission allowed |
| auto_release | input | 1 | Free pages after sending instead of logging them |
| tx_req | output | 1 | A page is ready for the transmitter |
| tx_page | output | 2 | Page at the head of the transmit queue |
| tx_done | input | 1 | Transmitter finished the head page |
| done_pop | input | 1 | Remove the oldest done entry |
| done_head | output | 8 | Oldest done entry or 0x80 |
| rx_req | input | 1 | Receive side requests a page |
| rx_grant | output | 1 | Receive request accepted this cycle |
| rx_page | output | 2 | Page granted to the receive side |
| rx_head | output | 8 | Oldest receive entry or 0x80 |
| alloc_result | output | 8 | Transmit allocation result, 0x80 on failure |
| alloc_irq | output | 1 | Allocation status flag |
| mem_size | output | 8 | Number of pages in the pool |
| used_count | output | 3 | Pages currently in use |

## Verification
A bitmap that loses or duplicates a page shows up at once in `used_count` and in the page numbers handed out by the next allocation or receive grant, one cycle after the command. A queue pointer or count that drifts is visible on `rx_head`, `done_head` or `tx_page` on the first read after the faulty push or pop, and a missed pending retry leaves `alloc_result` at 0x80 in the cycle after a release. The stimulus therefore reads these outputs after every operation instead of only at the end of a sequence.

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu #(
  parameter int NPAGE = 4,
  parameter int PW    = $clog2(NPAGE),
  parameter int CW    = $clog2(NPAGE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic [PW-1:0] pkt_sel,
  input  logic          tx_enable,
  input  logic          auto_release,
  output logic          tx_req,
  output logic [PW-1:0] tx_page,
  input  logic          tx_done,
  input  logic          done_pop,
  output logic [7:0]    done_head,
  input  logic          rx_req,
  output logic          rx_grant,
  output logic [PW-1:0] rx_page,
  output logic [7:0]    rx_head,
  output logic [7:0]    alloc_result,
  output logic          alloc_irq,
  output logic [7:0]    mem_size,
  output logic [CW-1:0] used_count
);
  localparam int QTX = 0, QDN = 1, QRX = 2;
  localparam logic [7:0] FAIL_CODE = 8'h80;

  logic [NPAGE-1:0] bitmap, bm_next, rel, m1;
  logic [7:0]       res_next;
  logic             irq_next, want_alloc, alloc_ok, tx_go;
  logic [PW-1:0]    alloc_pg;

  logic [PW-1:0] q_mem [3][NPAGE];
  logic [PW-1:0] q_hd  [3];
  logic [CW-1:0] q_cnt [3];
  logic [PW-1:0] q_din [3];
  logic [2:0]    q_push, q_pop, q_clr;

  function automatic logic [PW-1:0] first_free(input logic [NPAGE-1:0] m);
    first_free = '0;
    for (int i = NPAGE - 1; i >= 0; i--)
      if (!m[i]) first_free = PW'(i);
  endfunction

  function automatic logic [CW-1:0] pop_count(input logic [NPAGE-1:0] m);
    pop_count = '0;
    for (int i = 0; i < NPAGE; i++)
      pop_count = pop_count + CW'(m[i]);
  endfunction

  wire [2:0] code     = cmd_byte[7:5];
  wire       c_alloc  = cmd_valid && code == 3'd1;
  wire       c_reset  = cmd_valid && code == 3'd2;
  wire       c_rxpop  = cmd_valid && code == 3'd3;
  wire       c_rxfree = cmd_valid && code == 3'd4;
  wire       c_rel    = cmd_valid && code == 3'd5;
  wire       c_enq    = cmd_valid && code == 3'd6;
  wire       c_txclr  = cmd_valid && code == 3'd7;
  wire       pending  = alloc_result[7];

  assign used_count = pop_count(bitmap);
  assign mem_size   = 8'(NPAGE);
  assign tx_req     = tx_enable && q_cnt[QTX] != '0;
  assign tx_page    = q_mem[QTX][q_hd[QTX]];
  assign tx_go      = tx_done && tx_req;
  assign rx_page    = first_free(bitmap);
  assign rx_grant   = rx_req && !cmd_valid && !(&bitmap);
  assign rx_head    = q_cnt[QRX] == '0 ? FAIL_CODE : 8'(q_mem[QRX][q_hd[QRX]]);
  assign done_head  = q_cnt[QDN] == '0 ? FAIL_CODE : 8'(q_mem[QDN][q_hd[QDN]]);

  always_comb begin
    rel = '0;
    if (c_rel) rel[pkt_sel] = 1'b1;
    if (c_rxfree && q_cnt[QRX] != '0) rel[q_mem[QRX][q_hd[QRX]]] = 1'b1;
    if (tx_go && auto_release) rel[tx_page] = 1'b1;
    m1 = bitmap & ~rel;
    if (rx_grant) m1[rx_page] = 1'b1;
    want_alloc = c_alloc || (pending && |rel);
    alloc_ok   = want_alloc && !(&m1);
    alloc_pg   = first_free(m1);
    bm_next    = m1;
    if (alloc_ok) bm_next[alloc_pg] = 1'b1;
    res_next = alloc_result;
    irq_next = alloc_irq;
    if (c_alloc) begin
      res_next = FAIL_CODE;
      irq_next = 1'b0;
    end
    if (alloc_ok) begin
      res_next = 8'(alloc_pg);
      irq_next = 1'b1;
    end
    if (c_reset) begin
      bm_next  = '0;
      res_next = '0;
    end
  end

  always_comb begin
    q_push[QTX] = c_enq && q_cnt[QTX] != CW'(NPAGE);
    q_din[QTX]  = pkt_sel;
    q_pop[QTX]  = tx_go;
    q_clr[QTX]  = c_reset || c_txclr;
    q_push[QDN] = tx_go && !auto_release && q_cnt[QDN] != CW'(NPAGE);
    q_din[QDN]  = tx_page;
    q_pop[QDN]  = done_pop && q_cnt[QDN] != '0;
    q_clr[QDN]  = c_reset || c_txclr;
    q_push[QRX] = rx_grant;
    q_din[QRX]  = rx_page;
    q_pop[QRX]  = (c_rxpop || c_rxfree) && q_cnt[QRX] != '0;
    q_clr[QRX]  = c_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitmap       <= '0;
      alloc_result <= '0;
      alloc_irq    <= 1'b0;
    end else begin
      bitmap       <= bm_next;
      alloc_result <= res_next;
      alloc_irq    <= irq_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < 3; q++) begin
        q_hd[q]  <= '0;
        q_cnt[q] <= '0;
        for (int e = 0; e < NPAGE; e++) q_mem[q][e] <= '0;
      end
    end else begin
      for (int q = 0; q < 3; q++) begin
        if (q_clr[q]) begin
          q_hd[q]  <= '0;
          q_cnt[q] <= '0;
        end else begin
          if (q_push[q])
            q_mem[q][PW'((32'(q_hd[q]) + 32'(q_cnt[q])) % NPAGE)] <= q_din[q];
          if (q_pop[q])
            q_hd[q] <= (q_hd[q] == PW'(NPAGE - 1)) ? '0 : q_hd[q] + PW'(1);
          q_cnt[q] <= q_cnt[q] + CW'(q_push[q]) - CW'(q_pop[q]);
        end
      end
    end
  end

  assert_alloc_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_alloc && used_count < CW'(NPAGE) |=> !alloc_result[7] && alloc_irq);
  assert_alloc_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_alloc && used_count == CW'(NPAGE) && !tx_go |=> alloc_result == FAIL_CODE && !alloc_irq);
  assert_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_rel && pending && bitmap[pkt_sel] |=> !alloc_result[7] && alloc_irq);
  assert_mmu_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_reset |=> used_count == '0 && rx_head == FAIL_CODE && done_head == FAIL_CODE);
  assert_tx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !tx_req);
  assert_rx_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req && !cmd_valid && used_count < CW'(NPAGE) |-> rx_grant);
  assert_used_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    used_count <= CW'(NPAGE));
endmodule

// File: tb/sim_pkt_page_mmu.sv
`timescale 1ns/1ps
module sim_pkt_page_mmu;
  logic       clk = 0, rst_n = 0;
  logic       cmd_valid = 0, tx_enable = 0, auto_release = 0, tx_done = 0, done_pop = 0, rx_req = 0;
  logic [7:0] cmd_byte = 0;
  logic [1:0] pkt_sel = 0;
  logic       tx_req, rx_grant, alloc_irq;
  logic [1:0] tx_page, rx_page;
  logic [7:0] done_head, rx_head, alloc_result, mem_size;
  logic [2:0] used_count;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pkt_page_mmu u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b, input logic [1:0] s);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = b; pkt_sel = s;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_done;
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  // {cmd, sel, expected result, expected used, expected irq}
  localparam logic [21:0] VEC [11] = '{
    {8'h20, 2'd0, 8'h00, 3'd1, 1'b1},
    {8'h20, 2'd0, 8'h01, 3'd2, 1'b1},
    {8'h20, 2'd0, 8'h02, 3'd3, 1'b1},
    {8'h20, 2'd0, 8'h03, 3'd4, 1'b1},
    {8'h20, 2'd0, 8'h80, 3'd4, 1'b0},
    {8'hA0, 2'd2, 8'h02, 3'd4, 1'b1},
    {8'hA0, 2'd0, 8'h02, 3'd3, 1'b1},
    {8'h20, 2'd0, 8'h00, 3'd4, 1'b1},
    {8'h00, 2'd1, 8'h00, 3'd4, 1'b1},
    {8'h40, 2'd0, 8'h00, 3'd0, 1'b1},
    {8'h20, 2'd0, 8'h00, 3'd1, 1'b1}
  };

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset result", alloc_result, 0);
    chk("R2 reset irq", alloc_irq, 0);
    chk("R11 reset used", used_count, 0);
    chk("R5 reset rx_head", rx_head, 8'h80);
    chk("R5 reset done_head", done_head, 8'h80);
    chk("R8 reset tx_req", tx_req, 0);
    chk("R11 mem_size", mem_size, 4);

    // R1 R2 R3 R4: table of allocation, release, no-op and reset commands
    for (int i = 0; i < 11; i++) begin
      cmd(VEC[i][21:14], VEC[i][13:12]);
      chk($sformatf("R2/R3 vec%0d result", i), alloc_result, VEC[i][11:4]);
      chk($sformatf("R11 vec%0d used", i), used_count, VEC[i][3:1]);
      chk($sformatf("R1 vec%0d irq", i), alloc_irq, VEC[i][0]);
    end

    cmd(8'h40, 0);
    // R10: receive grants
    @(negedge clk); rx_req = 1; #1;
    chk("R10 grant", rx_grant, 1);
    chk("R10 page", rx_page, 0);
    @(negedge clk); #1;
    chk("R10 second page", rx_page, 1);
    @(negedge clk); rx_req = 0;
    chk("R5 rx_head oldest", rx_head, 0);
    chk("R11 used after rx", used_count, 2);
    @(negedge clk); rx_req = 1; cmd_valid = 1; cmd_byte = 8'h00; #1;
    chk("R10 refused during command", rx_grant, 0);
    @(negedge clk); rx_req = 0; cmd_valid = 0;
    chk("R10 no page taken", used_count, 2);
    // R6
    cmd(8'h60, 0);
    chk("R6 pop keeps page", used_count, 2);
    chk("R6 pop next head", rx_head, 1);
    cmd(8'h80, 0);
    chk("R6 pop+free used", used_count, 1);
    chk("R6 pop+free head", rx_head, 8'h80);
    cmd(8'h80, 0);
    chk("R6 empty pop+free", used_count, 1);

    cmd(8'h40, 0);
    for (int k = 0; k < 4; k++) cmd(8'h20, 0);
    @(negedge clk); rx_req = 1; #1;
    chk("R10 refused when full", rx_grant, 0);
    @(negedge clk); rx_req = 0;
    // R7 R8 R9
    for (int k = 0; k < 4; k++) cmd(8'hC0, 2'(k));
    cmd(8'hC0, 0);
    chk("R8 gated by enable", tx_req, 0);
    @(negedge clk); tx_enable = 1; #1;
    chk("R8 request", tx_req, 1);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R8 tx_page %0d", k), tx_page, k);
      pulse_done();
      chk("R9 done head", done_head, 0);
    end
    chk("R7 fifth enqueue ignored", tx_req, 0);
    chk("R9 no auto release", used_count, 4);
    @(negedge clk); done_pop = 1;
    @(negedge clk); done_pop = 0;
    chk("R9 done pop", done_head, 1);
    cmd(8'hE0, 0);
    chk("R12 done cleared", done_head, 8'h80);
    chk("R12 bitmap kept", used_count, 4);
    @(negedge clk); auto_release = 1;
    cmd(8'hC0, 2);
    chk("R8 auto page", tx_page, 2);
    pulse_done();
    chk("R9 auto release used", used_count, 3);
    chk("R9 auto release no log", done_head, 8'h80);
    chk("R8 queue drained", tx_req, 0);
    chk("R7 release via code", used_count, 3);
    cmd(8'hA0, 1);
    chk("R7 release used", used_count, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule